// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns an 8-bit virtual page number into a physical frame number. It reads a sparse two-level translation structure held in word-addressed memory. A requester pulses a walk request that carries the page number and the physical base of the top-level directory. The walker then issues one word read for the directory slot. If that slot is marked present, it issues a second read for the leaf slot, using an address built from the frame number the first read returned. A directory slot marked absent ends the walk after one read.

The result appears for a single cycle. It carries the page number, the frame number, the three protection bits and a fault code, so a translation cache can insert the result directly. Only one memory read is ever outstanding. The response latency may be any number of cycles. Requests that arrive while a walk is in flight are dropped.

With the default parameters, pages are 64 bytes (6 offset bits), physical addresses are 16 bits and frame numbers are 10 bits. The top 4 bits of the page number select one of 16 directory slots. The low 4 bits select one of 16 leaf slots.

Top module: `pt_walker`

## Requirements
- R1: After reset, `walk_done`, `mem_req` and `walk_busy` are all low.
- R2: The first read after an accepted request goes to the directory base (bits 1:0 forced to zero) plus 4 × `walk_vpn[7:4]`.
- R3: If bit 31 of the directory word is 0, the walk ends after exactly one read, with `done_fault` = 1 and `done_pfn` and `done_prot` at zero. The other bits of that word are ignored.
- R4: If bit 31 of the directory word is 1, the second read goes to (directory word bits 9:0) × 64 + 4 × `walk_vpn[3:0]`. Directory bits 30:10 do not affect it.
- R5: If bit 31 of the leaf word is 1, the walk ends after exactly two reads, with `done_fault` = 0, `done_pfn` = leaf bits 9:0 and `done_prot` = leaf bits 30:28.
- R6: If bit 31 of the leaf word is 0, `done_fault` = 2 and `done_pfn` and `done_prot` are zero.
- R7: `walk_done` rises in the cycle after the clock edge that samples the last response, and stays high for exactly one cycle.
- R8: A request seen while `walk_busy` is high is ignored. The current walk keeps its reads and its `done_vpn`. No further walk starts after it completes.
- R9: With page number 254, directory slot 15 holding frame 101 and leaf slot 14 holding frame 55, the result is frame 0x37.
- R10: Bits 1:0 of `walk_base` have no effect on any read address.
- R11: `mem_req` is high for one cycle per read, and no new read is issued until the previous one has been answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_req | input | 1 | Start a walk (taken only when idle) |
| walk_vpn | input | 8 | Virtual page number to translate |
| walk_base | input | 16 | Physical base of the directory |
| walk_busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | One-cycle word read strobe |
| mem_addr | output | 16 | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data is present this cycle |
| mem_rsp_data | input | 32 | Read data word |
| walk_done | output | 1 | One-cycle result strobe |
| done_vpn | output | 8 | Page number of the finished walk |
| done_pfn | output | 10 | Translated frame number |
| done_prot | output | 3 | Protection bits of the leaf entry |
| done_fault | output | 2 | 0 none, 1 directory absent, 2 leaf absent |

## Verification
A wrong state in the controller shows at the memory port within one or two cycles. It appears as a second strobe while a read is outstanding, a leaf read issued after an absent directory slot, or an address whose slot index does not match the request. A corrupted latched page number or frame number appears in the very next read address, or on `done_vpn` one cycle after the last response. A wrong transition near completion shows as a missing, late or stretched `walk_done`, or as activity on the memory port after the walk should be idle. The bench therefore checks every read address, the read count, and the exact cycle of the result for every page number, under several response latencies.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

   localparam int ENTRY_W   = 32;
   localparam int PRESENT_B = 31;
   localparam int PROT_HI   = 30;
   localparam int PROT_LO   = 28;
   localparam int PROT_W    = PROT_HI - PROT_LO + 1;
   localparam int SLOT_SH   = 2;   // log2 of the entry size in bytes

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_DIR  = 2'd1,
      FLT_LEAF = 2'd2
   } walk_fault_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_DIR,
      ST_WT_DIR,
      ST_RD_LEAF,
      ST_WT_LEAF,
      ST_DONE
   } walk_state_e;

endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr
   import pt_walk_pkg::*;
#(
   parameter int VPN_W        = 8,
   parameter int DIR_IDX_W    = 4,
   parameter int OFF_W        = 6,
   parameter int PADDR_W      = 16,
   parameter bit BASE_ALIGNED = 1'b0
) (
   input  logic [VPN_W-1:0]           vpn,
   input  logic [PADDR_W-1:0]         dir_base,
   input  logic [PADDR_W-OFF_W-1:0]   leaf_pfn,
   input  logic                       sel_leaf,
   output logic [PADDR_W-1:0]         addr
);

   localparam int LEAF_IDX_W = VPN_W - DIR_IDX_W;

   logic [DIR_IDX_W-1:0]  dir_idx;
   logic [LEAF_IDX_W-1:0] leaf_idx;
   logic [PADDR_W-1:0]    base_word;
   logic [PADDR_W-1:0]    dir_off;
   logic [PADDR_W-1:0]    leaf_off;
   logic [PADDR_W-1:0]    dir_addr;
   logic [PADDR_W-1:0]    leaf_addr;

   assign dir_idx   = vpn[VPN_W-1 -: DIR_IDX_W];
   assign leaf_idx  = vpn[LEAF_IDX_W-1:0];
   assign base_word = {dir_base[PADDR_W-1:SLOT_SH], {SLOT_SH{1'b0}}};
   assign dir_off   = PADDR_W'(dir_idx) << SLOT_SH;
   assign leaf_off  = PADDR_W'(leaf_idx) << SLOT_SH;

   generate
      if (BASE_ALIGNED) begin : g_dir_or
         // base assumed aligned to the whole directory: no carry chain
         assign dir_addr = base_word | dir_off;
      end else begin : g_dir_add
         assign dir_addr = base_word + dir_off;
      end
   endgenerate

   // leaf slots always fit inside one page, so the join needs no adder
   assign leaf_addr = {leaf_pfn, {OFF_W{1'b0}}} | leaf_off;
   assign addr      = sel_leaf ? leaf_addr : dir_addr;

endmodule

// File: rtl/pt_walk_entry.sv
module pt_walk_entry
   import pt_walk_pkg::*;
#(
   parameter int PFN_W = 10
) (
   input  logic [ENTRY_W-1:0] word,
   output logic               present,
   output logic [PROT_W-1:0]  prot,
   output logic [PFN_W-1:0]   pfn
);

   generate
      if (PFN_W > PROT_LO) begin : g_bad_pfn
         $error("frame field overlaps the protection bits");
      end
   endgenerate

   assign present = word[PRESENT_B];
   assign prot    = word[PROT_HI:PROT_LO];
   assign pfn     = word[PFN_W-1:0];

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
   import pt_walk_pkg::*;
#(
   parameter int VPN_W   = 8,
   parameter int PADDR_W = 16,
   parameter int PFN_W   = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VPN_W-1:0]   req_vpn,
   input  logic [PADDR_W-1:0] req_base,
   input  logic               rsp_valid,
   input  logic               ent_present,
   input  logic [PFN_W-1:0]   ent_pfn,
   input  logic [PROT_W-1:0]  ent_prot,
   output logic [VPN_W-1:0]   vpn_q,
   output logic [PADDR_W-1:0] base_q,
   output logic [PFN_W-1:0]   leaf_pfn_q,
   output logic               sel_leaf,
   output logic               mem_req,
   output logic               busy,
   output logic               done,
   output logic [PFN_W-1:0]   res_pfn,
   output logic [PROT_W-1:0]  res_prot,
   output walk_fault_e        res_fault
);

   walk_state_e state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         vpn_q      <= '0;
         base_q     <= '0;
         leaf_pfn_q <= '0;
         res_pfn    <= '0;
         res_prot   <= '0;
         res_fault  <= FLT_NONE;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  vpn_q  <= req_vpn;
                  base_q <= req_base;
                  state  <= ST_RD_DIR;
               end
            end
            ST_RD_DIR: state <= ST_WT_DIR;
            ST_WT_DIR: begin
               if (rsp_valid) begin
                  if (ent_present) begin
                     leaf_pfn_q <= ent_pfn;
                     state      <= ST_RD_LEAF;
                  end else begin
                     res_pfn   <= '0;
                     res_prot  <= '0;
                     res_fault <= FLT_DIR;
                     state     <= ST_DONE;
                  end
               end
            end
            ST_RD_LEAF: state <= ST_WT_LEAF;
            ST_WT_LEAF: begin
               if (rsp_valid) begin
                  if (ent_present) begin
                     res_pfn   <= ent_pfn;
                     res_prot  <= ent_prot;
                     res_fault <= FLT_NONE;
                  end else begin
                     res_pfn   <= '0;
                     res_prot  <= '0;
                     res_fault <= FLT_LEAF;
                  end
                  state <= ST_DONE;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_req  = (state == ST_RD_DIR) || (state == ST_RD_LEAF);
   assign sel_leaf = (state == ST_RD_LEAF) || (state == ST_WT_LEAF);
   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_DONE);

   // read counter used only by the checks below
   logic [1:0] rd_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)                           rd_cnt <= '0;
      else if (state == ST_IDLE && req_valid) rd_cnt <= '0;
      else if (mem_req)                     rd_cnt <= rd_cnt + 2'd1;
   end

   // R11
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R3
   dir_fault_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_fault == FLT_DIR) |-> (rd_cnt == 2'd1));
   // R5
   leaf_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_fault != FLT_DIR) |-> (rd_cnt == 2'd2));
   // R6
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_fault != FLT_NONE) |-> (res_pfn == '0 && res_prot == '0));
   // R8
   hold_vpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(vpn_q));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walk_pkg::*;
#(
   parameter int VPN_W        = 8,
   parameter int DIR_IDX_W    = 4,
   parameter int OFF_W        = 6,
   parameter int PADDR_W      = 16,
   parameter bit BASE_ALIGNED = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     walk_req,
   input  logic [VPN_W-1:0]         walk_vpn,
   input  logic [PADDR_W-1:0]       walk_base,
   output logic                     walk_busy,
   output logic                     mem_req,
   output logic [PADDR_W-1:0]       mem_addr,
   input  logic                     mem_rsp_valid,
   input  logic [ENTRY_W-1:0]       mem_rsp_data,
   output logic                     walk_done,
   output logic [VPN_W-1:0]         done_vpn,
   output logic [PADDR_W-OFF_W-1:0] done_pfn,
   output logic [PROT_W-1:0]        done_prot,
   output logic [1:0]               done_fault
);

   localparam int PFN_W      = PADDR_W - OFF_W;
   localparam int LEAF_IDX_W = VPN_W - DIR_IDX_W;

   generate
      if (DIR_IDX_W < 1 || LEAF_IDX_W < 1) begin : g_bad_split
         $error("page number must split into two non-empty indices");
      end
      if (LEAF_IDX_W + SLOT_SH > OFF_W) begin : g_bad_leaf
         $error("a leaf table must fit inside one page");
      end
      if (PFN_W < 1 || PFN_W > PROT_LO) begin : g_bad_pfn
         $error("frame number width out of range");
      end
   endgenerate

   logic [VPN_W-1:0]   vpn_q;
   logic [PADDR_W-1:0] base_q;
   logic [PFN_W-1:0]   leaf_pfn_q;
   logic               sel_leaf;
   logic               ent_present;
   logic [PROT_W-1:0]  ent_prot;
   logic [PFN_W-1:0]   ent_pfn;
   logic [PFN_W-1:0]   res_pfn;
   logic [PROT_W-1:0]  res_prot;
   walk_fault_e        res_fault;

   pt_walk_ctrl #(
      .VPN_W   (VPN_W),
      .PADDR_W (PADDR_W),
      .PFN_W   (PFN_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (walk_req),
      .req_vpn     (walk_vpn),
      .req_base    (walk_base),
      .rsp_valid   (mem_rsp_valid),
      .ent_present (ent_present),
      .ent_pfn     (ent_pfn),
      .ent_prot    (ent_prot),
      .vpn_q       (vpn_q),
      .base_q      (base_q),
      .leaf_pfn_q  (leaf_pfn_q),
      .sel_leaf    (sel_leaf),
      .mem_req     (mem_req),
      .busy        (walk_busy),
      .done        (walk_done),
      .res_pfn     (res_pfn),
      .res_prot    (res_prot),
      .res_fault   (res_fault)
   );

   pt_walk_entry #(
      .PFN_W (PFN_W)
   ) u_entry (
      .word    (mem_rsp_data),
      .present (ent_present),
      .prot    (ent_prot),
      .pfn     (ent_pfn)
   );

   pt_walk_addr #(
      .VPN_W        (VPN_W),
      .DIR_IDX_W    (DIR_IDX_W),
      .OFF_W        (OFF_W),
      .PADDR_W      (PADDR_W),
      .BASE_ALIGNED (BASE_ALIGNED)
   ) u_addr (
      .vpn      (vpn_q),
      .dir_base (base_q),
      .leaf_pfn (leaf_pfn_q),
      .sel_leaf (sel_leaf),
      .addr     (mem_addr)
   );

   assign done_vpn   = vpn_q;
   assign done_pfn   = res_pfn;
   assign done_prot  = res_prot;
   assign done_fault = res_fault;

   // R10
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[SLOT_SH-1:0] == '0));

endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;

   localparam logic [15:0] DBASE = 16'h0400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        walk_req = 1'b0;
   logic [7:0]  walk_vpn = '0;
   logic [15:0] walk_base = '0;
   logic        walk_busy;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        walk_done;
   logic [7:0]  done_vpn;
   logic [9:0]  done_pfn;
   logic [2:0]  done_prot;
   logic [1:0]  done_fault;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pt_walker uut (
      .clk(clk), .rst_n(rst_n), .walk_req(walk_req), .walk_vpn(walk_vpn),
      .walk_base(walk_base), .walk_busy(walk_busy), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .walk_done(walk_done), .done_vpn(done_vpn),
      .done_pfn(done_pfn), .done_prot(done_prot), .done_fault(done_fault)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] dir_word(input int d);
      logic [31:0] w;
      w        = '0;
      w[31]    = (d % 3) != 1;
      w[30:28] = 3'(d);
      w[27:10] = 18'(d * 1234 + 5);
      w[9:0]   = (d == 15) ? 10'd101 : 10'(200 + d);
      return w;
   endfunction

   function automatic logic [31:0] leaf_word(input int d, input int t);
      logic [31:0] w;
      w        = '0;
      w[27:10] = 18'(t * 99 + d);
      if (d == 15 && t == 14) begin
         w[31] = 1'b1; w[30:28] = 3'd5; w[9:0] = 10'd55;
      end else begin
         w[31]    = ((d + t) % 4) != 3;
         w[30:28] = 3'(d + t);
         w[9:0]   = 10'((d * 16 + t) * 3 + 1);
      end
      return w;
   endfunction

   function automatic logic [31:0] mem_word(input logic [15:0] a);
      int f, t, d;
      if (a >= DBASE && a < DBASE + 16'd64) return dir_word(int'(a - DBASE) >> 2);
      f = int'(a) >> 6;
      t = (int'(a) >> 2) & 15;
      d = (f == 101) ? 15 : f - 200;
      return leaf_word(d, t);
   endfunction

   task automatic run_walk(input int vpn, input int lat, input bit poke);
      int d, t, nrd, pend, rsp_c;
      bit got, outst;
      logic [31:0] pw, lw;
      logic [15:0] last_a;
      d = vpn >> 4; t = vpn & 15;
      pw = dir_word(d); lw = leaf_word(d, t);
      nrd = 0; pend = 0; rsp_c = -10; got = 0; outst = 0; last_a = '0;
      @(negedge clk);
      walk_req = 1'b1; walk_vpn = 8'(vpn); walk_base = DBASE | 16'(vpn & 3);
      @(negedge clk);
      if (poke) walk_vpn = 8'(vpn) ^ 8'hA5; else walk_req = 1'b0;
      for (int c = 0; c < 60 && !got; c++) begin
         mem_rsp_valid = 1'b0;
         if (walk_done) begin
            got = 1;
            chk(c == rsp_c + 1, "R7 done one cycle after last response", c, rsp_c + 1);
            chk(done_vpn == 8'(vpn), "R8 done_vpn", done_vpn, vpn);
            if (!pw[31]) begin
               chk(done_fault == 2'd1, "R3 fault code", done_fault, 1);
               chk(nrd == 1, "R3 read count", nrd, 1);
               chk(done_pfn == 0 && done_prot == 0, "R3 zero result", done_pfn, 0);
            end else if (!lw[31]) begin
               chk(done_fault == 2'd2, "R6 fault code", done_fault, 2);
               chk(nrd == 2, "R6 read count", nrd, 2);
               chk(done_pfn == 0 && done_prot == 0, "R6 zero result", done_pfn, 0);
            end else begin
               chk(done_fault == 2'd0, "R5 fault code", done_fault, 0);
               chk(nrd == 2, "R5 read count", nrd, 2);
               chk(done_pfn == lw[9:0], "R5 pfn", done_pfn, lw[9:0]);
               chk(done_prot == lw[30:28], "R5 prot", done_prot, lw[30:28]);
            end
         end
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = mem_word(last_a);
               rsp_c = c;
               outst = 0;
            end
         end
         if (mem_req && !got) begin
            chk(!outst, "R11 read while one outstanding", 1, 0);
            nrd++;
            if (nrd == 1)
               chk(mem_addr == DBASE + 16'(d * 4), "R2 R10 directory address",
                   mem_addr, DBASE + d * 4);
            else
               chk(mem_addr == 16'(pw[9:0] * 64 + t * 4), "R4 leaf address",
                   mem_addr, pw[9:0] * 64 + t * 4);
            last_a = mem_addr;
            pend = lat;
            outst = 1;
         end
         if (!got) @(negedge clk);
      end
      walk_req = 1'b0;
      mem_rsp_valid = 1'b0;
      chk(got, "R7 walk completed", got, 1);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!mem_req && !walk_busy && !walk_done, "R8 R7 idle after walk",
             {mem_req, walk_busy, walk_done}, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!walk_done && !mem_req && !walk_busy, "R1 reset outputs",
          {walk_done, mem_req, walk_busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!walk_done && !mem_req && !walk_busy, "R1 idle after reset",
          {walk_done, mem_req, walk_busy}, 0);
      for (int v = 0; v < 256; v++) run_walk(v, 1 + (v % 4), (v % 5) == 0);
      run_walk(254, 2, 1'b0);
      chk(done_pfn == 10'h37, "R9 example translation", done_pfn, 'h37);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R7 actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule